// File: doc/BRIEF.md
# Conversion-Start Edge Power Mode Decoder

This block lives on the device side of a converter's serial port. It watches two asynchronous inputs, the conversion-start strobe and the serial clock, and derives a power state from them. Conversion-start rising edges are counted, and any serial-clock rising edge clears the count. A short run of starts with no clock edge between them drops the device into nap. A longer run drops it into sleep. Any serial-clock edge brings it back to normal operation.

The block reports the current mode. It drives an enable for the voltage reference, which is off only in sleep. It also raises a reference-ready flag. In nap the reference stays powered, so the flag stays high. After a wake from sleep, the flag returns only once two settling intervals have elapsed in sequence: a slew interval and then a longer settle interval. Both intervals are counted in system-clock cycles.

Both inputs are resynchronized to a fast system clock before edge detection. Power switching of analog circuits is modelled only through the enable and the ready flag.

Top module: `cpm_power_mode`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `mode_o` is 2'b00 (normal), `ref_en_o` is 1 and `ref_ready_o` is 1.
- R2: A rising edge on either input, applied between clock edges, changes `mode_o` at the third rising `clk_i` edge after the input change and not earlier.
- R3: Two conversion-start rising edges with no serial-clock rising edge between them set `mode_o` to 2'b01 (nap). A single such edge leaves the mode at normal.
- R4: Four conversion-start rising edges with no serial-clock rising edge between them set `mode_o` to 2'b10 (sleep). `ref_en_o` and `ref_ready_o` go low on the same clock edge that the mode becomes sleep.
- R5: The edge count saturates at four. A third start edge leaves the block in nap, and further start edges in sleep leave it in sleep.
- R6: Every serial-clock rising edge clears the start-edge count to zero, so counting restarts after it.
- R7: A serial-clock rising edge in nap returns `mode_o` to normal, and `ref_ready_o` stays high throughout nap and the wake.
- R8: After a wake from sleep, `ref_en_o` is high from the edge where the mode becomes normal. `ref_ready_o` rises exactly SLEW_CYC + SETTLE_CYC clock edges after that edge.
- R9: When a serial-clock rising edge and a conversion-start rising edge are detected in the same cycle, the count is cleared first and the start is then counted, leaving a count of one.
- R10: Re-entering sleep while the reference is still settling abandons the settling. The next wake restarts the full delay. Entering nap during settling does not stop it.
- R11: Only rising edges count. A start input held high counts once, and a falling serial-clock edge does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Asynchronous conversion-start strobe |
| ser_clk_i | input | 1 | Asynchronous serial clock |
| mode_o | output | 2 | Power mode: 00 normal, 01 nap, 10 sleep |
| ref_en_o | output | 1 | Reference enable, low only in sleep |
| ref_ready_o | output | 1 | Reference settled flag |

## Verification
The bench goes after the counting boundaries. One start must not nap the block. A third start must not reach sleep, and a fifth must not wrap the count. A design that counted levels, or that cleared on falling serial-clock edges, would fall into nap too early or never reach it.

Start and serial-clock edges are also applied in the same cycle. A design with the wrong priority would either ignore that start or fail to clear the count.

The wake from sleep is timed to the exact cycle, and the same timing is repeated after a second sleep that interrupts settling. A sequencer that resumed its old count, or skipped the slew phase, would raise the ready flag early. The entry edges into nap and sleep are also checked cycle by cycle, so a one-cycle lag in dropping the ready flag would be caught.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

   typedef enum logic [1:0] {
      CPM_RUN   = 2'b00,
      CPM_NAP   = 2'b01,
      CPM_SLEEP = 2'b10
   } cpm_mode_e;

   typedef enum logic [1:0] {
      REF_OFF    = 2'd0,
      REF_SLEW   = 2'd1,
      REF_SETTLE = 2'd2,
      REF_ON     = 2'd3
   } cpm_ref_e;

   function automatic int cpm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cpm_sync_edge.sv
module cpm_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/cpm_edge_count.sv
module cpm_edge_count
   import cpm_pkg::*;
#(
   parameter int NAP_EDGES   = 2,
   parameter int SLEEP_EDGES = 4,
   parameter int CNT_W       = $clog2(SLEEP_EDGES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_rise_i,
   input  logic             sclk_rise_i,
   output logic [CNT_W-1:0] cnt_q_o,
   output cpm_mode_e        mode_d_o
);

   localparam logic [CNT_W-1:0] SAT = CNT_W'(SLEEP_EDGES);
   localparam logic [CNT_W-1:0] NAP = CNT_W'(NAP_EDGES);

   logic [CNT_W-1:0] cnt_q, base, cnt_d;

   always_comb begin
      base  = sclk_rise_i ? '0 : cnt_q;
      cnt_d = base;
      if (start_rise_i && (base != SAT)) cnt_d = base + 1'b1;
   end

   always_comb begin
      if (cnt_d == SAT)      mode_d_o = CPM_SLEEP;
      else if (cnt_d >= NAP) mode_d_o = CPM_NAP;
      else                   mode_d_o = CPM_RUN;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_q_o = cnt_q;

endmodule

// File: rtl/cpm_ref_seq.sv
module cpm_ref_seq
   import cpm_pkg::*;
#(
   parameter int SLEW_CYC   = 200,
   parameter int SETTLE_CYC = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_d_i,
   output logic ready_o
);

   localparam int LONGEST = cpm_max(SLEW_CYC, SETTLE_CYC);
   localparam int TMR_W   = $clog2(LONGEST + 1);
   localparam logic [TMR_W-1:0] SLEW_LD   = TMR_W'(SLEW_CYC - 1);
   localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);

   cpm_ref_e         st_q;
   logic [TMR_W-1:0] tmr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= REF_ON;
         tmr_q <= '0;
      end else if (sleep_d_i) begin
         st_q  <= REF_OFF;
         tmr_q <= '0;
      end else begin
         unique case (st_q)
            REF_OFF: begin
               st_q  <= REF_SLEW;
               tmr_q <= SLEW_LD;
            end
            REF_SLEW: begin
               if (tmr_q == '0) begin
                  st_q  <= REF_SETTLE;
                  tmr_q <= SETTLE_LD;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            REF_SETTLE: begin
               if (tmr_q == '0) st_q  <= REF_ON;
               else             tmr_q <= tmr_q - 1'b1;
            end
            default: st_q <= REF_ON;
         endcase
      end
   end

   assign ready_o = (st_q == REF_ON);

endmodule

// File: rtl/cpm_power_mode.sv
module cpm_power_mode
   import cpm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int NAP_EDGES   = 2,
   parameter int SLEEP_EDGES = 4,
   parameter int SLEW_CYC    = 200,
   parameter int SETTLE_CYC  = 1000
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       conv_start_i,
   input  logic       ser_clk_i,
   output logic [1:0] mode_o,
   output logic       ref_en_o,
   output logic       ref_ready_o
);

   localparam int CNT_W = $clog2(SLEEP_EDGES + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cpm_power_mode: SYNC_STAGES must be at least 2");
      end
      if (NAP_EDGES < 2 || SLEEP_EDGES <= NAP_EDGES) begin : g_bad_edges
         $error("cpm_power_mode: need 2 <= NAP_EDGES < SLEEP_EDGES");
      end
      if (SLEW_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_delay
         $error("cpm_power_mode: settling delays must be at least 1");
      end
   endgenerate

   logic             start_rise, sclk_rise;
   logic [CNT_W-1:0] cnt_q;
   cpm_mode_e        mode_d, mode_q;

   cpm_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_start (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (conv_start_i),
      .rise_o  (start_rise)
   );

   cpm_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_sclk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ser_clk_i),
      .rise_o  (sclk_rise)
   );

   cpm_edge_count #(
      .NAP_EDGES   (NAP_EDGES),
      .SLEEP_EDGES (SLEEP_EDGES),
      .CNT_W       (CNT_W)
   ) i_count (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_rise_i (start_rise),
      .sclk_rise_i  (sclk_rise),
      .cnt_q_o      (cnt_q),
      .mode_d_o     (mode_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= CPM_RUN;
      else         mode_q <= mode_d;
   end

   cpm_ref_seq #(
      .SLEW_CYC   (SLEW_CYC),
      .SETTLE_CYC (SETTLE_CYC)
   ) i_ref (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sleep_d_i (mode_d == CPM_SLEEP),
      .ready_o   (ref_ready_o)
   );

   assign mode_o   = mode_q;
   assign ref_en_o = (mode_q != CPM_SLEEP);

endmodule

// File: rtl/cpm_power_mode_chk.sv
module cpm_power_mode_chk #(
   parameter int SLEEP_EDGES = 4,
   parameter int SLEW_CYC    = 200,
   parameter int SETTLE_CYC  = 1000,
   parameter int CNT_W       = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [1:0]       mode_o,
   input logic             ref_en_o,
   input logic             ref_ready_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic             start_rise,
   input logic             sclk_rise
);

   localparam int TOTAL = SLEW_CYC + SETTLE_CYC;
   localparam int AW_W  = $clog2(TOTAL + 2);

   logic [AW_W-1:0] awake_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   awake_q <= AW_W'(TOTAL);
      else if (mode_o == 2'b10)      awake_q <= '0;
      else if (awake_q < AW_W'(TOTAL)) awake_q <= awake_q + 1'b1;
   end

   p_sleep_ref_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10) |-> (!ref_ready_o && !ref_en_o));

   p_cnt_saturate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(SLEEP_EDGES));

   p_sclk_wakes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_rise |=> (mode_o == 2'b00));

   p_ready_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ref_ready_o) && mode_o != 2'b10) |-> ref_ready_o);

   p_ready_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ref_ready_o) |-> (awake_q >= AW_W'(TOTAL)));

   p_no_edge_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_rise && !sclk_rise) |=> $stable(cnt_q));

   p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o != 2'b11);

endmodule

bind cpm_power_mode cpm_power_mode_chk #(
   .SLEEP_EDGES (SLEEP_EDGES),
   .SLEW_CYC    (SLEW_CYC),
   .SETTLE_CYC  (SETTLE_CYC),
   .CNT_W       (CNT_W)
) i_cpm_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .mode_o      (mode_o),
   .ref_en_o    (ref_en_o),
   .ref_ready_o (ref_ready_o),
   .cnt_q       (cnt_q),
   .start_rise  (start_rise),
   .sclk_rise   (sclk_rise)
);

// File: tb/test_cpm_power_mode.sv
`timescale 1ns/1ps
module test_cpm_power_mode;

   localparam int SLEW   = 8;
   localparam int SETTLE = 40;
   localparam int TOTAL  = SLEW + SETTLE;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_start = 1'b0;
   logic       ser_clk = 1'b0;
   logic [1:0] mode;
   logic       ref_en, ref_ready;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   cpm_power_mode #(.SLEW_CYC(SLEW), .SETTLE_CYC(SETTLE)) i_cpm_power_mode (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .conv_start_i (conv_start),
      .ser_clk_i    (ser_clk),
      .mode_o       (mode),
      .ref_en_o     (ref_en),
      .ref_ready_o  (ref_ready)
   );

   // vector: {op[1:0] (bit0 start, bit1 sclk), mode[1:0], ref_en, ref_ready}
   localparam int NVEC = 13;
   localparam logic [5:0] VEC [NVEC] = '{
      {2'b01, 2'b00, 1'b1, 1'b1},   // R3 single start stays normal
      {2'b10, 2'b00, 1'b1, 1'b1},   // R6 clear
      {2'b01, 2'b00, 1'b1, 1'b1},   // R6 count restarts at one
      {2'b01, 2'b01, 1'b1, 1'b1},   // R3 nap
      {2'b10, 2'b00, 1'b1, 1'b1},   // R7 wake from nap
      {2'b11, 2'b00, 1'b1, 1'b1},   // R9 both in one cycle
      {2'b01, 2'b01, 1'b1, 1'b1},   // R9 start counted after clear
      {2'b01, 2'b01, 1'b1, 1'b1},   // R5 third start stays nap
      {2'b01, 2'b10, 1'b0, 1'b0},   // R4 sleep
      {2'b01, 2'b10, 1'b0, 1'b0},   // R5 fifth start stays sleep
      {2'b10, 2'b00, 1'b1, 1'b0},   // R8 wake, not ready yet
      {2'b01, 2'b00, 1'b1, 1'b0},   // R10 settling continues
      {2'b01, 2'b01, 1'b1, 1'b0}    // R10 nap during settling
   };

   task automatic check(input string req, input string what,
                        input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic pulse(input logic [1:0] op);
      @(negedge clk);
      if (op[0]) conv_start = 1'b1;
      if (op[1]) ser_clk = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (op[0]) conv_start = 1'b0;
      if (op[1]) ser_clk = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wake_measure(input string req);
      @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req, "mode at wake", {2'b0, mode}, 4'h0);
      check(req, "enable at wake", {3'b0, ref_en}, 4'h1);
      check(req, "ready at wake", {3'b0, ref_ready}, 4'h0);
      repeat (TOTAL - 1) @(posedge clk);
      @(negedge clk);
      check(req, "ready one cycle early", {3'b0, ref_ready}, 4'h0);
      @(posedge clk);
      @(negedge clk);
      check(req, "ready on time", {3'b0, ref_ready}, 4'h1);
      ser_clk = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "mode in reset", {2'b0, mode}, 4'h0);
      check("R1", "enable in reset", {3'b0, ref_en}, 4'h1);
      check("R1", "ready in reset", {3'b0, ref_ready}, 4'h1);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1", "state after reset", {mode, ref_en, ref_ready}, 4'b0011);

      for (int v = 0; v < NVEC; v++) begin
         pulse(VEC[v][5:4]);
         check($sformatf("vector %0d", v), "mode/en/ready",
               {mode, ref_en, ref_ready}, VEC[v][3:0]);
      end

      repeat (60) @(posedge clk);
      @(negedge clk);
      check("R10", "ready after nap during settling", {mode, ref_en, ref_ready}, 4'b0111);

      // R2 and R7: exact latency of a wake from nap
      ser_clk = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2", "mode before third edge", {mode, ref_en, ref_ready}, 4'b0111);
      @(posedge clk);
      @(negedge clk);
      check("R7", "mode at third edge", {mode, ref_en, ref_ready}, 4'b0011);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);

      // R11: held start counts once
      conv_start = 1'b1;
      repeat (20) @(negedge clk);
      check("R11", "held start", {2'b0, mode}, 4'h0);
      conv_start = 1'b0;
      repeat (10) @(negedge clk);
      check("R11", "after release", {2'b0, mode}, 4'h0);
      pulse(2'b01);
      check("R11", "second start naps", {2'b0, mode}, 4'h1);

      // R11: falling serial clock does not clear
      pulse(2'b10);
      ser_clk = 1'b1;
      repeat (6) @(negedge clk);
      pulse(2'b01);
      pulse(2'b01);
      check("R11", "nap with sclk high", {2'b0, mode}, 4'h1);
      ser_clk = 1'b0;
      repeat (6) @(negedge clk);
      check("R11", "sclk fall ignored", {2'b0, mode}, 4'h1);

      // R4: ready drops on the edge sleep is entered
      pulse(2'b01);
      conv_start = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R4", "before sleep edge", {mode, ref_en, ref_ready}, 4'b0111);
      @(posedge clk);
      @(negedge clk);
      check("R4", "on sleep edge", {mode, ref_en, ref_ready}, 4'b1000);
      conv_start = 1'b0;
      repeat (4) @(negedge clk);

      wake_measure("R8");

      // R10: sleep during settling restarts the delay
      repeat (4) @(negedge clk);
      repeat (4) pulse(2'b01);
      check("R10", "sleep again", {mode, ref_en, ref_ready}, 4'b1000);
      pulse(2'b10);
      check("R10", "woken, settling", {mode, ref_en, ref_ready}, 4'b0010);
      repeat (4) pulse(2'b01);
      check("R10", "sleep mid-settle", {mode, ref_en, ref_ready}, 4'b1000);
      wake_measure("R10");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule